// File: doc/BRIEF.md
# Four-Channel DMA Programming and Address Core

This block is the host-facing register file and address generator of a four-channel DMA engine. Each channel holds a 16-bit base and current address, a 16-bit base and current count, an 8-bit page, a 4-bit mode and a mask bit. The host programs everything through one 8-bit write port. A single shared byte pointer steers the halves of the 16-bit address and count registers. The pointer alternates between low and high byte, and a dedicated select returns it to the low byte.

A transfer engine outside this block pulses a strobe with a channel number for each transfer. If the channel may transfer, the block returns, one cycle later, an acknowledge and the 24-bit bus address (page above the 16-bit offset). On the channel's last transfer it also returns a terminal-count pulse. It then either reloads the channel from its base values (auto-init) or masks the channel and raises a sticky status bit (single-cycle).

Write select map (`wr_sel`):
- 0–3: address of channels 0–3.
- 4–7: count of channels 0–3.
- 8–11: page of channels 0–3.
- 12: mode.
- 13: single mask.
- 14: clear byte pointer.
- 15: no effect.

Top module: `dma_chan_core`

## Requirements
- R1: Synchronous reset leaves all four channels masked (`mask_o`=4'hF), all status bits clear, the byte pointer on the low byte, and `xfer_ack`, `xfer_tc`, `xfer_addr` at zero.
- R2: Writes to any address or count select (0–7) share one byte pointer. The first write after the pointer is cleared goes to bits 7:0, the next to bits 15:8, and so on alternately. A write to select 14 with any data returns the pointer to the low byte.
- R3: Writing a byte of a base address or base count writes the same byte of the matching current register, so the next transfer uses the newly programmed value.
- R4: A mode write (select 12) stores its fields for the channel in data bits 1:0. Bits 3:2 give the transfer kind: 00 verify, 01 to memory, 10 from memory, 11 illegal. Bit 4 set enables auto-init. Bit 5 set selects decrement. Bits 7:6 have no effect on addressing or counting.
- R5: A single-mask write (select 13) sets the mask of the channel in data bits 1:0 when data bit 2 is 1, and clears it when bit 2 is 0. Data bits 7:3 are ignored.
- R6: A strobe is accepted only when its channel is unmasked, the channel's kind is not illegal, and `wr_en` is low in that cycle. An accepted strobe gives `xfer_ack`=1 in the next cycle. A refused strobe gives `xfer_ack`=0 and changes no state.
- R7: On acceptance, `xfer_addr` is the channel page in bits 23:16 and the current address in bits 15:0. The page does not change when the offset wraps.
- R8: After each accepted transfer that is not the last, the current address moves by one (up or down per mode bit 5), wrapping modulo 2^16.
- R9: A count value of N gives N+1 accepted transfers. `xfer_tc` is 1 together with `xfer_ack` on the last one, when the current count was zero.
- R10: With auto-init set, the last transfer reloads the current address and count from the base values. The channel stays unmasked.
- R11: With auto-init clear, the last transfer sets the channel's mask bit and its `tc_flags` bit.
- R12: A mode write to a channel clears that channel's `tc_flags` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Register select (see map) |
| wr_data | input | 8 | Host write data |
| xfer_stb | input | 1 | One-cycle transfer request |
| xfer_ch | input | 2 | Channel of the transfer request |
| xfer_ack | output | 1 | Registered: previous request accepted |
| xfer_addr | output | 24 | Registered bus address of the accepted transfer |
| xfer_tc | output | 1 | Registered: accepted transfer was the channel's last |
| mask_o | output | 4 | Per-channel mask bits (1 = disabled) |
| tc_flags | output | 4 | Per-channel sticky terminal-count status |

## Verification
The assertions check these properties on every cycle:
- The byte pointer flips on each 16-bit register write and is low after a clear.
- The count steps down by one and the address moves by one on each ordinary transfer.
- A single-cycle terminal count masks its channel; an auto-init terminal count reloads from the base values and keeps the channel enabled.
- A masked channel or a colliding host write never yields an acknowledge.

The bench's scenarios are the only way to show that:
- bytes land in the right half when the pointer is shared between registers and cleared mid-pair;
- the page stays fixed across an offset wrap;
- ignored mask and mode bits really have no effect;
- the full sequence of addresses over a reload is correct.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    XK_VERIFY   = 2'b00,
    XK_TO_MEM   = 2'b01,
    XK_FROM_MEM = 2'b10,
    XK_ILLEGAL  = 2'b11
  } xfer_kind_e;

  // stored copy of mode data bits 5:2
  typedef struct packed {
    logic       dec;
    logic       auto_init;
    xfer_kind_e kind;
  } chan_mode_t;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic hi_q
);

  always_ff @(posedge clk) begin
    if (rst)      hi_q <= 1'b0;
    else if (clr) hi_q <= 1'b0;
    else if (adv) hi_q <= ~hi_q;
  end

  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (rst)
    adv && !clr |=> hi_q != $past(hi_q)); // R2
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> !hi_q); // R2

endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          byte_hi,
  input  logic          ld_page,
  input  logic          ld_mode,
  input  logic          ld_mask,
  input  logic [7:0]    din,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [PW-1:0] page_q,
  output chan_mode_t    mode_q,
  output logic          masked,
  output logic          tc_flag,
  output logic          last
);

  localparam int HW = AW - 8;

  logic [AW-1:0] base_addr, base_cnt, cur_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      page_q    <= '0;
      mode_q    <= '0;
      masked    <= 1'b1;
      tc_flag   <= 1'b0;
    end else begin
      if (ld_addr) begin
        if (byte_hi) begin
          base_addr[AW-1:8] <= din[HW-1:0];
          cur_addr[AW-1:8]  <= din[HW-1:0];
        end else begin
          base_addr[7:0] <= din;
          cur_addr[7:0]  <= din;
        end
      end
      if (ld_cnt) begin
        if (byte_hi) begin
          base_cnt[AW-1:8] <= din[HW-1:0];
          cur_cnt[AW-1:8]  <= din[HW-1:0];
        end else begin
          base_cnt[7:0] <= din;
          cur_cnt[7:0]  <= din;
        end
      end
      if (ld_page) page_q <= din[PW-1:0];
      if (ld_mode) begin
        mode_q  <= chan_mode_t'(din[5:2]);
        tc_flag <= 1'b0;
      end
      if (ld_mask) masked <= din[2];
      if (step) begin
        if (last && mode_q.auto_init) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= mode_q.dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
        if (last && !mode_q.auto_init) begin
          masked  <= 1'b1;
          tc_flag <= 1'b1;
        end
      end
    end
  end

  AST_SINGLE_TC_MASKS: assert property (@(posedge clk) disable iff (rst)
    step && last && !mode_q.auto_init |=> masked && tc_flag); // R11
  AST_AUTO_RELOADS: assert property (@(posedge clk) disable iff (rst)
    step && last && mode_q.auto_init |=>
      cur_addr == $past(base_addr) && !masked && last == ($past(base_cnt) == '0)); // R10
  AST_ADDR_MOVES: assert property (@(posedge clk) disable iff (rst)
    step && !last |=>
      cur_addr == ($past(mode_q.dec) ? AW'($past(cur_addr) - 1'b1)
                                     : AW'($past(cur_addr) + 1'b1))); // R8
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    step && !last && (cur_cnt == AW'(1)) |=> last); // R9
  AST_MODE_CLEARS_TC: assert property (@(posedge clk) disable iff (rst)
    ld_mode |=> !tc_flag); // R12

endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int PW     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [3:0]                  wr_sel,
  input  logic [7:0]                  wr_data,
  input  logic                        xfer_stb,
  input  logic [$clog2(NUM_CH)-1:0]   xfer_ch,
  output logic                        xfer_ack,
  output logic [PW+AW-1:0]            xfer_addr,
  output logic                        xfer_tc,
  output logic [NUM_CH-1:0]           mask_o,
  output logic [NUM_CH-1:0]           tc_flags
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [3:0] SEL_CNT0  = 4'(NUM_CH);
  localparam logic [3:0] SEL_PAGE0 = 4'(2 * NUM_CH);
  localparam logic [3:0] SEL_MODE  = 4'(3 * NUM_CH);
  localparam logic [3:0] SEL_MASK  = 4'(3 * NUM_CH + 1);
  localparam logic [3:0] SEL_CLR   = 4'(3 * NUM_CH + 2);

  logic hit_addr, hit_cnt, hit_page, hit_mode, hit_mask, hit_clr;
  logic byte_hi, accept;
  logic [CH_W-1:0] sel_ch, dat_ch;

  logic [AW-1:0] cur_addr_a [NUM_CH];
  logic [PW-1:0] page_a     [NUM_CH];
  chan_mode_t    mode_a     [NUM_CH];
  logic [NUM_CH-1:0] last_v;

  assign sel_ch   = wr_sel[CH_W-1:0];
  assign dat_ch   = wr_data[CH_W-1:0];
  assign hit_addr = wr_en && (wr_sel < SEL_CNT0);
  assign hit_cnt  = wr_en && (wr_sel >= SEL_CNT0) && (wr_sel < SEL_PAGE0);
  assign hit_page = wr_en && (wr_sel >= SEL_PAGE0) && (wr_sel < SEL_MODE);
  assign hit_mode = wr_en && (wr_sel == SEL_MODE);
  assign hit_mask = wr_en && (wr_sel == SEL_MASK);
  assign hit_clr  = wr_en && (wr_sel == SEL_CLR);

  dma_byte_ptr u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (hit_clr),
    .adv  (hit_addr || hit_cnt),
    .hi_q (byte_hi)
  );

  assign accept = xfer_stb && !wr_en && !mask_o[xfer_ch] &&
                  (mode_a[xfer_ch].kind != XK_ILLEGAL);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan_slice #(.AW(AW), .PW(PW)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .ld_addr  (hit_addr && sel_ch == CH_W'(i)),
      .ld_cnt   (hit_cnt  && sel_ch == CH_W'(i)),
      .byte_hi  (byte_hi),
      .ld_page  (hit_page && sel_ch == CH_W'(i)),
      .ld_mode  (hit_mode && dat_ch == CH_W'(i)),
      .ld_mask  (hit_mask && dat_ch == CH_W'(i)),
      .din      (wr_data),
      .step     (accept && xfer_ch == CH_W'(i)),
      .cur_addr (cur_addr_a[i]),
      .page_q   (page_a[i]),
      .mode_q   (mode_a[i]),
      .masked   (mask_o[i]),
      .tc_flag  (tc_flags[i]),
      .last     (last_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_ack  <= 1'b0;
      xfer_tc   <= 1'b0;
      xfer_addr <= '0;
    end else begin
      xfer_ack <= accept;
      xfer_tc  <= accept && last_v[xfer_ch];
      if (accept) xfer_addr <= {page_a[xfer_ch], cur_addr_a[xfer_ch]};
    end
  end

  AST_RESET_MASKS_ALL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&mask_o) && (tc_flags == '0)); // R1
  AST_BLOCKED_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    xfer_stb && (wr_en || mask_o[xfer_ch]) |=> !xfer_ack); // R6
  AST_ACK_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> $past(xfer_stb)); // R6
  AST_TC_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    xfer_tc |-> xfer_ack); // R9

endmodule

// File: tb/dma_chan_core_tb.sv
`timescale 1ns/1ps
module dma_chan_core_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic xfer_stb = 1'b0;
  logic [1:0] xfer_ch = '0;
  logic xfer_ack, xfer_tc;
  logic [23:0] xfer_addr;
  logic [3:0] mask_o, tc_flags;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_chan_core u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_stb(xfer_stb), .xfer_ch(xfer_ch), .xfer_ack(xfer_ack),
    .xfer_addr(xfer_addr), .xfer_tc(xfer_tc), .mask_o(mask_o), .tc_flags(tc_flags)
  );

  // behavioural reference model
  int m_badr[4], m_cadr[4], m_bcnt[4], m_ccnt[4], m_page[4], m_mode[4];
  int m_mask[4], m_tcs[4];
  int m_ptr, m_ack, m_tc, m_addr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_badr[i] = 0; m_cadr[i] = 0; m_bcnt[i] = 0; m_ccnt[i] = 0;
        m_page[i] = 0; m_mode[i] = 0; m_mask[i] = 1; m_tcs[i] = 0;
      end
      m_ptr = 0; m_ack = 0; m_tc = 0; m_addr = 0;
    end else begin
      int s, d, c;
      s = wr_sel; d = wr_data; c = xfer_ch;
      m_ack = 0; m_tc = 0;
      if (wr_en) begin
        if (s < 8) begin
          if (s < 4) begin
            if (m_ptr) begin
              m_badr[s%4] = (m_badr[s%4] & 'hFF) | (d << 8);
              m_cadr[s%4] = (m_cadr[s%4] & 'hFF) | (d << 8);
            end else begin
              m_badr[s%4] = (m_badr[s%4] & 'hFF00) | d;
              m_cadr[s%4] = (m_cadr[s%4] & 'hFF00) | d;
            end
          end else begin
            if (m_ptr) begin
              m_bcnt[s%4] = (m_bcnt[s%4] & 'hFF) | (d << 8);
              m_ccnt[s%4] = (m_ccnt[s%4] & 'hFF) | (d << 8);
            end else begin
              m_bcnt[s%4] = (m_bcnt[s%4] & 'hFF00) | d;
              m_ccnt[s%4] = (m_ccnt[s%4] & 'hFF00) | d;
            end
          end
          m_ptr = 1 - m_ptr;
        end else if (s < 12) m_page[s-8] = d;
        else if (s == 12) begin m_mode[d%4] = d / 4; m_tcs[d%4] = 0; end
        else if (s == 13) m_mask[d%4] = (d / 4) % 2;
        else if (s == 14) m_ptr = 0;
      end else if (xfer_stb && m_mask[c] == 0 && (m_mode[c] % 4) != 3) begin
        m_ack = 1;
        m_addr = m_page[c] * 65536 + m_cadr[c];
        if (m_ccnt[c] == 0) m_tc = 1;
        if (m_tc && ((m_mode[c] / 4) % 2)) begin
          m_cadr[c] = m_badr[c];
          m_ccnt[c] = m_bcnt[c];
        end else begin
          if ((m_mode[c] / 8) % 2) m_cadr[c] = (m_cadr[c] + 65535) % 65536;
          else                     m_cadr[c] = (m_cadr[c] + 1) % 65536;
          m_ccnt[c] = (m_ccnt[c] + 65535) % 65536;
          if (m_tc) begin m_mask[c] = 1; m_tcs[c] = 1; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [3:0] em, et;
      for (int i = 0; i < 4; i++) begin em[i] = m_mask[i][0]; et[i] = m_tcs[i][0]; end
      chk("R6 ack", {31'd0, xfer_ack}, m_ack);
      chk("R7 addr", {8'd0, xfer_addr}, m_addr);
      chk("R9 tc", {31'd0, xfer_tc}, m_tc);
      chk("R11 mask", {28'd0, mask_o}, {28'd0, em});
      chk("R12 flags", {28'd0, tc_flags}, {28'd0, et});
    end
  end

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set16(input logic [3:0] s, input logic [15:0] v);
    wr(s, v[7:0]); wr(s, v[15:8]);
  endtask

  task automatic strobe(input logic [1:0] c);
    @(negedge clk); xfer_stb = 1'b1; xfer_ch = c;
    @(negedge clk); xfer_stb = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mask after reset", {28'd0, mask_o}, 32'hF);
    chk("R1 flags after reset", {28'd0, tc_flags}, 32'h0);
    chk("R1 ack after reset", {31'd0, xfer_ack}, 32'h0);

    // single-cycle, increment, channel 1
    wr(14, 8'h00);
    set16(1, 16'h1234);
    set16(5, 16'h0002);
    wr(9, 8'h5A);
    wr(12, 8'h09);
    wr(13, 8'h01);
    strobe(1);
    chk("R3 first address from base", {8'd0, xfer_addr}, 32'h5A1234);
    chk("R6 ack unmasked", {31'd0, xfer_ack}, 32'h1);
    strobe(1);
    chk("R8 increment", {8'd0, xfer_addr}, 32'h5A1235);
    chk("R9 no tc early", {31'd0, xfer_tc}, 32'h0);
    strobe(1);
    chk("R9 tc on last", {31'd0, xfer_tc}, 32'h1);
    chk("R11 channel masked", {31'd0, mask_o[1]}, 32'h1);
    chk("R11 status set", {31'd0, tc_flags[1]}, 32'h1);
    strobe(1);
    chk("R6 masked refused", {31'd0, xfer_ack}, 32'h0);
    wr(12, 8'h09);
    chk("R12 mode write clears status", {31'd0, tc_flags[1]}, 32'h0);

    // shared pointer, clear mid-pair, auto-init decrement, channel 2
    wr(14, 8'h00);
    wr(2, 8'h11);
    wr(14, 8'h00);
    wr(2, 8'h22);
    wr(6, 8'h00);
    wr(6, 8'h01);
    wr(2, 8'h44);
    wr(10, 8'h03);
    wr(12, 8'h36);
    wr(13, 8'h02);
    strobe(2);
    chk("R2 shared pointer address", {8'd0, xfer_addr}, 32'h034422);
    strobe(2);
    chk("R8 decrement", {8'd0, xfer_addr}, 32'h034421);
    chk("R10 tc pulse", {31'd0, xfer_tc}, 32'h1);
    strobe(2);
    chk("R10 reloaded address", {8'd0, xfer_addr}, 32'h034422);
    chk("R10 stays unmasked", {31'd0, mask_o[2]}, 32'h0);

    // wrap with fixed page, ignored bits, channel 3
    wr(14, 8'h00);
    set16(3, 16'hFFFF);
    set16(7, 16'h0005);
    wr(11, 8'h07);
    wr(12, 8'hCB);
    wr(13, 8'hFB);
    chk("R5 upper mask bits ignored", {31'd0, mask_o[3]}, 32'h0);
    strobe(3);
    chk("R4 mode bits 7:6 no effect", {8'd0, xfer_addr}, 32'h07FFFF);
    strobe(3);
    chk("R7 page fixed over wrap", {8'd0, xfer_addr}, 32'h070000);
    wr(13, 8'h07);
    chk("R5 mask set", {31'd0, mask_o[3]}, 32'h1);
    strobe(3);
    chk("R5 masked channel refused", {31'd0, xfer_ack}, 32'h0);

    // illegal kind, then count zero, channel 0
    wr(12, 8'h0C);
    wr(13, 8'h00);
    chk("R5 mask cleared", {31'd0, mask_o[0]}, 32'h0);
    strobe(0);
    chk("R4 illegal kind refused", {31'd0, xfer_ack}, 32'h0);
    wr(12, 8'h08);
    strobe(0);
    chk("R9 zero count single transfer", {31'd0, xfer_tc}, 32'h1);
    chk("R11 masked after one", {31'd0, mask_o[0]}, 32'h1);

    // strobe colliding with a host write (unused select)
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd15; wr_data = 8'hFF;
    xfer_stb = 1'b1; xfer_ch = 2'd2;
    @(negedge clk);
    wr_en = 1'b0; xfer_stb = 1'b0;
    chk("R6 refused during write", {31'd0, xfer_ack}, 32'h0);
    strobe(2);
    chk("R6 state unchanged after refusal", {8'd0, xfer_addr}, 32'h034421);
    chk("R10 second tc", {31'd0, xfer_tc}, 32'h1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule